// File: doc/BRIEF.md
# Sub-Frame Doppler DC Notch

This block sits in the range-Doppler stream right after the Doppler transform. The Doppler axis of a frame is made of several sub-frames of 16 bins each; a frame of three sub-frames carries 48 bins. Every sample comes in with its Doppler bin index. The block works out where the sample falls inside its own sub-frame. It forces both the I and Q parts to zero when that position lies close to zero Doppler. This removes stationary clutter that survives earlier stages.

The notch is set by a small width value. It zeroes the lowest `width` positions of each sub-frame and the highest `width-1` positions, so the notch is one bin wider on the low side. A width of zero turns the notch off. The width is captured only on the first sample of a frame, marked by a start-of-frame flag, so one frame never mixes two settings. The output is registered, with one cycle of latency, and the valid flag and bin index travel with the data.

Top module: `doppler_dc_notch`

## Requirements
- R1: The position within a sub-frame is bits [3:0] of `in_bin`; the same mask therefore applies in every 16-bin sub-frame (for example bins 16, 17, 31, 32, 33 and 47 are notched at width 2).
- R2: With a non-zero effective width w, a sample is zeroed exactly when its position p satisfies p < w or p > 16 − w (w = 1 zeroes only position 0, w = 3 zeroes 0..2 and 14..15, w = 8 keeps only position 8).
- R3: With an effective width of zero, every sample passes with its I and Q values unchanged.
- R4: For a notched sample both `out_i` and `out_q` are zero. A sample that is not notched keeps both of its values.
- R5: `notch_width` is taken in only on a cycle with `in_valid` and `in_sof` both high. It applies to that sample and to every later sample until the next such cycle. Changes to `notch_width` at any other time, and `in_sof` with `in_valid` low, have no effect.
- R6: After reset and before the first captured width, the effective width is 2, which notches positions 0, 1 and 15.
- R7: `out_valid`, `out_bin`, `out_i` and `out_q` show the sample presented one clock edge earlier; `out_valid` is low on the cycle after a cycle with `in_valid` low.
- R8: While reset (`rst_n` low, sampled at the clock edge) is applied, all outputs are driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| notch_width | input | 4 | Requested notch width, captured at frame start |
| in_valid | input | 1 | Input sample qualifier |
| in_sof | input | 1 | First sample of a frame |
| in_bin | input | 6 | Doppler bin index of the input sample |
| in_i | input | 16 | In-phase value, signed |
| in_q | input | 16 | Quadrature value, signed |
| out_valid | output | 1 | Output sample qualifier |
| out_bin | output | 6 | Doppler bin index of the output sample |
| out_i | output | 16 | In-phase value after the notch |
| out_q | output | 16 | Quadrature value after the notch |

## Verification
Each result is due exactly one rising edge after the sample is presented. This holds for the zeroing decision, the passed data, the bin index and the valid flag. A width captured on a start-of-frame sample already governs that same sample's output. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which puts each check half a cycle after the register that produces it. Streamed sweeps present one sample per cycle, and each output is compared against the sample driven in the cycle before.

// File: rtl/dcn_pkg.sv
// Package: shared default sizes for the sub-frame Doppler DC notch.
// Assumes: sub-frame length is a power of two.
package dcn_pkg;
    localparam int DCN_DATA_W    = 16;  // I/Q sample width
    localparam int DCN_BIN_W     = 6;   // Doppler bin index width
    localparam int DCN_SF_BINS   = 16;  // bins per sub-frame
    localparam int DCN_WIDTH_W   = 4;   // notch width field
    localparam int DCN_WIDTH_RST = 2;   // width in force after reset
endpackage

// File: rtl/dcn_width_hold.sv
// Module: holds the notch width for the current frame.
// Captures width_in when load is high; the captured value also applies
// combinationally to the loading sample itself.
// Assumes: load is asserted only on the first valid sample of a frame.
module dcn_width_hold #(
    parameter int WIDTH_W   = dcn_pkg::DCN_WIDTH_W,
    parameter int WIDTH_RST = dcn_pkg::DCN_WIDTH_RST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [WIDTH_W-1:0] width_in,
    output logic [WIDTH_W-1:0] width_eff
);
    localparam logic [WIDTH_W-1:0] RST_VAL = WIDTH_W'(WIDTH_RST);

    logic [WIDTH_W-1:0] held_q;

    // Register the width at frame start, default after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    held_q <= RST_VAL;
        else if (load) held_q <= width_in;
    end

    // Select the newly loaded width for the loading sample itself.
    always_comb width_eff = load ? width_in : held_q;

    // R5
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> $stable(held_q));

    // R6
    width_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !load) |-> (width_eff == RST_VAL));
endmodule

// File: rtl/dcn_mask.sv
// Module: decides whether a sub-frame position falls inside the notch.
// Zero for width 0; otherwise pos < width or pos > SF_BINS - width.
// Assumes: pos already reduced to the position within one sub-frame.
module dcn_mask #(
    parameter int SF_BINS = dcn_pkg::DCN_SF_BINS,
    parameter int WIDTH_W = dcn_pkg::DCN_WIDTH_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(SF_BINS)-1:0] pos,
    input  logic [WIDTH_W-1:0]         width,
    output logic                       notch
);
    localparam int POS_W = $clog2(SF_BINS);
    localparam int CMP_W = ((POS_W > WIDTH_W) ? POS_W : WIDTH_W) + 2;

    logic [CMP_W-1:0] pos_x;
    logic [CMP_W-1:0] width_x;
    logic [CMP_W-1:0] upper;

    // Widen operands and derive the upper edge of the notch.
    always_comb begin
        pos_x   = CMP_W'(pos);
        width_x = CMP_W'(width);
        upper   = CMP_W'(SF_BINS) - width_x;
        notch   = (width_x != '0) && ((pos_x < width_x) || (pos_x > upper));
    end

    // R3
    width_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (width == '0) |-> !notch);

    // R2
    low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((width != '0) && (pos == '0)) |-> notch);
endmodule

// File: rtl/dcn_out_reg.sv
// Module: one-cycle output register; zeroes every data lane when kill is set.
// Lanes are generated so I and Q share one structure.
// Assumes: kill is valid in the same cycle as the input sample.
module dcn_out_reg #(
    parameter int DATA_W = dcn_pkg::DCN_DATA_W,
    parameter int BIN_W  = dcn_pkg::DCN_BIN_W,
    parameter int LANES  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [BIN_W-1:0]             in_bin,
    input  logic [LANES-1:0][DATA_W-1:0] in_data,
    input  logic                         kill,
    output logic                         out_valid,
    output logic [BIN_W-1:0]             out_bin,
    output logic [LANES-1:0][DATA_W-1:0] out_data
);
    // Register valid and bin index alongside the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bin   <= '0;
        end else begin
            out_valid <= in_valid;
            out_bin   <= in_bin;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Register one data lane, forced to zero inside the notch.
        always_ff @(posedge clk) begin
            if (!rst_n)    out_data[g] <= '0;
            else if (kill) out_data[g] <= '0;
            else           out_data[g] <= in_data[g];
        end
    end

    // R7
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R7
    bin_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_bin == $past(in_bin)));
endmodule

// File: rtl/doppler_dc_notch.sv
// Module: streaming DC notch on range-Doppler samples, repeated per sub-frame.
// Takes the sub-frame position from the low bits of the bin index, holds
// the width for a whole frame and registers the result with one cycle
// of latency.
// Assumes: in_sof marks the first valid sample of every frame.
module doppler_dc_notch #(
    parameter int DATA_W    = dcn_pkg::DCN_DATA_W,
    parameter int BIN_W     = dcn_pkg::DCN_BIN_W,
    parameter int SF_BINS   = dcn_pkg::DCN_SF_BINS,
    parameter int WIDTH_W   = dcn_pkg::DCN_WIDTH_W,
    parameter int WIDTH_RST = dcn_pkg::DCN_WIDTH_RST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH_W-1:0] notch_width,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [BIN_W-1:0]   in_bin,
    input  logic [DATA_W-1:0]  in_i,
    input  logic [DATA_W-1:0]  in_q,
    output logic               out_valid,
    output logic [BIN_W-1:0]   out_bin,
    output logic [DATA_W-1:0]  out_i,
    output logic [DATA_W-1:0]  out_q
);
    localparam int POS_W = $clog2(SF_BINS);

    logic                    load;
    logic [WIDTH_W-1:0]      width_eff;
    logic                    notch;
    logic [1:0][DATA_W-1:0]  lane_in;
    logic [1:0][DATA_W-1:0]  lane_out;

    // Frame start qualifies the width capture.
    always_comb load = in_valid && in_sof;

    // Pack I and Q into lanes and unpack the registered result.
    always_comb begin
        lane_in[0] = in_i;
        lane_in[1] = in_q;
        out_i      = lane_out[0];
        out_q      = lane_out[1];
    end

    dcn_width_hold #(
        .WIDTH_W   (WIDTH_W),
        .WIDTH_RST (WIDTH_RST)
    ) u_width (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .width_in  (notch_width),
        .width_eff (width_eff)
    );

    // R1: position is the low bits of the bin index
    dcn_mask #(
        .SF_BINS (SF_BINS),
        .WIDTH_W (WIDTH_W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .pos   (in_bin[POS_W-1:0]),
        .width (width_eff),
        .notch (notch)
    );

    dcn_out_reg #(
        .DATA_W (DATA_W),
        .BIN_W  (BIN_W),
        .LANES  (2)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bin    (in_bin),
        .in_data   (lane_in),
        .kill      (notch),
        .out_valid (out_valid),
        .out_bin   (out_bin),
        .out_data  (lane_out)
    );

    // R4
    zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(notch)) |-> ((out_i == '0) && (out_q == '0)));

    // R4
    pass_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(notch)) |->
            ((out_i == $past(in_i)) && (out_q == $past(in_q))));
endmodule

// File: tb/sim_doppler_dc_notch.sv
module sim_doppler_dc_notch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  notch_width = 4'd0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [5:0]  in_bin = '0;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        out_valid;
    logic [5:0]  out_bin;
    logic [15:0] out_i;
    logic [15:0] out_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    doppler_dc_notch u0 (
        .clk(clk), .rst_n(rst_n), .notch_width(notch_width),
        .in_valid(in_valid), .in_sof(in_sof), .in_bin(in_bin),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
        .out_bin(out_bin), .out_i(out_i), .out_q(out_q)
    );

    // Vector: {width[3:0], bin[5:0], i[15:0], q[15:0], notched}
    localparam int NV = 24;
    localparam logic [42:0] VEC [NV] = '{
        {4'd2,  6'd0,  16'h1234, 16'h0F0F, 1'b1},
        {4'd2,  6'd1,  16'h7FFF, 16'h8000, 1'b1},
        {4'd2,  6'd2,  16'h1111, 16'h2222, 1'b0},
        {4'd2,  6'd14, 16'hFFFF, 16'h0001, 1'b0},
        {4'd2,  6'd15, 16'hA5A5, 16'h5A5A, 1'b1},
        {4'd2,  6'd16, 16'h0101, 16'h0202, 1'b1},
        {4'd2,  6'd31, 16'h3333, 16'h4444, 1'b1},
        {4'd2,  6'd33, 16'h5555, 16'h6666, 1'b1},
        {4'd2,  6'd34, 16'h7777, 16'h8888, 1'b0},
        {4'd2,  6'd47, 16'h9999, 16'hAAAA, 1'b1},
        {4'd1,  6'd0,  16'h0BAD, 16'h0C0D, 1'b1},
        {4'd1,  6'd15, 16'h1357, 16'h2468, 1'b0},
        {4'd1,  6'd16, 16'h0042, 16'h0043, 1'b1},
        {4'd0,  6'd0,  16'hDEAD, 16'hBEEF, 1'b0},
        {4'd0,  6'd47, 16'hCAFE, 16'hF00D, 1'b0},
        {4'd3,  6'd13, 16'h0A0A, 16'h0B0B, 1'b0},
        {4'd3,  6'd14, 16'h0C0C, 16'h0D0D, 1'b1},
        {4'd8,  6'd8,  16'h1EE7, 16'h2EE7, 1'b0},
        {4'd8,  6'd7,  16'h3EE7, 16'h4EE7, 1'b1},
        {4'd8,  6'd9,  16'h5EE7, 16'h6EE7, 1'b1},
        {4'd15, 6'd1,  16'h7EE7, 16'h0EE7, 1'b1},
        {4'd4,  6'd36, 16'h1001, 16'h2002, 1'b0},
        {4'd4,  6'd35, 16'h3003, 16'h4004, 1'b1},
        {4'd3,  6'd2,  16'h5005, 16'h6006, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference notch rule from the requirements (R1, R2, R3)
    function automatic bit ref_notch(input int w, input int bin);
        int p = bin % 16;
        return (w != 0) && ((p < w) || (p > 16 - w));
    endfunction

    // Drive one sample on the falling edge; output is due at the next one.
    task automatic step(input bit v, input bit s, input logic [5:0] b,
                        input logic [15:0] di, input logic [15:0] dq);
        in_valid = v; in_sof = s; in_bin = b; in_i = di; in_q = dq;
        @(negedge clk);
    endtask

    task automatic chk_sample(input string req, input bit notched,
                              input logic [5:0] b, input logic [15:0] di,
                              input logic [15:0] dq);
        chk(req, {out_valid, out_bin}, {1'b1, b});
        chk(req, {out_i, out_q}, notched ? 32'h0 : {di, dq});
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: outputs zero under reset even with active inputs
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_bin = 6'd5; in_i = 16'h1234; in_q = 16'h5678;
        notch_width = 4'd0;
        @(negedge clk); @(negedge clk);
        chk("R8 reset", {out_valid, out_bin, out_i, out_q}, '0);
        in_valid = 1'b0; in_sof = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R6: default width 2 before any frame start, notch_width ignored
        notch_width = 4'd0;
        step(1, 0, 6'd0,  16'h0100, 16'h0200); chk_sample("R6 pos0",  1, 6'd0,  16'h0100, 16'h0200);
        step(1, 0, 6'd1,  16'h0101, 16'h0201); chk_sample("R6 pos1",  1, 6'd1,  16'h0101, 16'h0201);
        step(1, 0, 6'd2,  16'h0102, 16'h0202); chk_sample("R6 pos2",  0, 6'd2,  16'h0102, 16'h0202);
        step(1, 0, 6'd14, 16'h0103, 16'h0203); chk_sample("R6 pos14", 0, 6'd14, 16'h0103, 16'h0203);
        step(1, 0, 6'd15, 16'h0104, 16'h0204); chk_sample("R6 pos15", 1, 6'd15, 16'h0104, 16'h0204);

        // Table walk: each vector is its own frame start (R1 R2 R3 R4 R5)
        for (int k = 0; k < NV; k++) begin
            notch_width = VEC[k][42:39];
            step(1, 1, VEC[k][38:33], VEC[k][32:17], VEC[k][16:1]);
            chk_sample("R2 vector", VEC[k][0], VEC[k][38:33], VEC[k][32:17], VEC[k][16:1]);
        end

        // R5: width change without frame start is ignored (held width 3)
        notch_width = 4'd0;
        step(1, 0, 6'd2,  16'h7001, 16'h7002); chk_sample("R5 hold", 1, 6'd2,  16'h7001, 16'h7002);
        // R5: sof with valid low does not capture
        step(0, 1, 6'd9,  16'h7003, 16'h7004);
        chk("R7 idle", {26'h0, out_valid}, 64'h0);
        step(1, 0, 6'd18, 16'h7005, 16'h7006); chk_sample("R5 sof idle", 1, 6'd18, 16'h7005, 16'h7006);

        // R3: width 0 frame, all 48 bins streamed back to back pass unchanged
        notch_width = 4'd0;
        for (int b = 0; b < 48; b++) begin
            step(1, b == 0, 6'(b), 16'(b * 3 + 1), 16'(16'hF000 + b));
            chk_sample("R3 sweep", 0, 6'(b), 16'(b * 3 + 1), 16'(16'hF000 + b));
        end

        // R1: width 2 frame across three sub-frames, streamed back to back
        notch_width = 4'd2;
        for (int b = 0; b < 48; b++) begin
            step(1, b == 0, 6'(b), 16'(16'h4000 + b), 16'(16'h8000 + b));
            chk_sample("R1 sweep", ref_notch(2, b), 6'(b), 16'(16'h4000 + b), 16'(16'h8000 + b));
        end

        // R2: width 5 frame, streamed
        notch_width = 4'd5;
        for (int b = 0; b < 48; b++) begin
            step(1, b == 0, 6'(b), 16'(16'h2000 + b), 16'(16'h3000 + b));
            chk_sample("R2 sweep", ref_notch(5, b), 6'(b), 16'(16'h2000 + b), 16'(16'h3000 + b));
        end

        // R7: valid low drops out_valid on the next cycle
        step(0, 0, 6'd0, 16'h0, 16'h0);
        chk("R7 valid low", {26'h0, out_valid}, 64'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule